// File: doc/BRIEF.md
# Micro-op PC breakpoint and step unit

This unit sits beside a sequencer that issues micro-ops and watches every retired micro-op together with its 64-bit program counter. A host programs it through a small APB-style register port: an arm register, a step count, and two 64-bit address breakpoints. Each breakpoint is held as a low and a high 32-bit word.

The unit raises sticky event flags in three cases: a retired PC equals an armed breakpoint address, a programmed number of micro-ops has retired since stepping was armed, or the host has requested an immediate pause and the micro-op in flight retires. While the force-pause enable is set, any raised flag drives the pause request towards the sequencer. The host clears the flags by writing ones to the status word.

The register port has no wait states. A write takes effect on the clock edge where `psel`, `penable` and `pwrite` are all high. Read data is a combinational function of `paddr`.

Top module: `uop_bkpt_unit`

## Requirements
- R1: After reset the arm register (byte offset 0x004) reads 0x007: bit 0 breakpoint enable, bit 1 profile-table enable and bit 2 force-pause enable are set, and all other bits are clear. The step count, all four address words and the status word read zero, and `pause_req` is low.
- R2: The following locations read back what was last written:
  - step count at 0x008 (32 bits);
  - address 0 low/high at 0x018/0x01C;
  - address 1 low/high at 0x020/0x024;
  - arm register at 0x004, of which only bits 8:0 are stored and the upper bits read zero.
- R3: Any other offset, including misaligned ones, reads zero. A write to such an offset changes no register.
- R4: When arm bit 3 (step-valid) goes from 0 to 1, the unit counts retired micro-ops. On the clock edge of the retire that makes the count equal the step count, it sets status bit 1 (step flag, also on `evt_step`). This happens once per arming. A step count of zero never fires.
- R5: Clearing step-valid resets the internal count at once, so re-arming counts from zero again.
- R6: A retire whose 64-bit PC equals {high,low} of breakpoint k sets status bit 0 (instruction-break flag, also on `evt_ins`) on that edge. This requires arm bit 0 and the breakpoint's valid bit (bit 4 for k=0, bit 5 for k=1) to be set. A PC that differs in any bit does not set it.
- R7: While arm bit 8 (immediate pause) is set, the next retire sets status bit 2 (immediate-pause flag). Without a retire, the flag stays clear.
- R8: Status flags at 0x040 are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: `pause_req` is high exactly when arm bit 2 is set and at least one status flag is set.
- R10: Cycles with `rt_valid` low raise no flag, whatever `rt_pc` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Write when high |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data (combinational on paddr) |
| rt_valid | input | 1 | A micro-op retires this cycle |
| rt_pc | input | 64 | PC of the retiring micro-op |
| pause_req | output | 1 | Pause request to the sequencer |
| evt_ins | output | 1 | Instruction-break flag |
| evt_step | output | 1 | Step-count flag |

## Verification
The properties assume that a retire is a single-cycle strobe whose PC is valid only while `rt_valid` is high. They also assume the status word changes only through retires and register writes. The stimulus drives inputs on the falling edge and keeps each retire to one cycle. It changes arm bits only between retires, so no write and retire race for the same flag. Random PCs are drawn from a mix that includes exact breakpoint values, values one flipped bit away from them, and unrelated values, with the enables randomised.

// File: rtl/uwb_pkg.sv
package uwb_pkg;
    localparam int ARM_W  = 9;
    localparam int NUM_BP = 2;
    localparam int EV_W   = 3;

    // arm register bit positions
    localparam int B_IEN  = 0;
    localparam int B_PROF = 1;
    localparam int B_FPE  = 2;
    localparam int B_STEP = 3;
    localparam int B_AV0  = 4;
    localparam int B_IMM  = 8;

    localparam logic [ARM_W-1:0] ARM_RST = 9'h007;

    // status flag positions
    localparam int EV_INS  = 0;
    localparam int EV_STEP = 1;
    localparam int EV_IMM  = 2;

    // byte offsets
    localparam int OFF_ARM  = 'h004;
    localparam int OFF_STEP = 'h008;
    localparam int OFF_BP0  = 'h018;
    localparam int OFF_STAT = 'h040;
endpackage

// File: rtl/uwb_regs.sv
module uwb_regs
    import uwb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int PC_W   = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          psel,
    input  logic                          penable,
    input  logic                          pwrite,
    input  logic [ADDR_W-1:0]             paddr,
    input  logic [DATA_W-1:0]             pwdata,
    input  logic [EV_W-1:0]               status,
    output logic [DATA_W-1:0]             prdata,
    output logic                          arm_ien,
    output logic                          arm_fpe,
    output logic                          arm_step,
    output logic [NUM_BP-1:0]             arm_av,
    output logic                          arm_imm,
    output logic [DATA_W-1:0]             step_num,
    output logic [NUM_BP-1:0][PC_W-1:0]   bp_addr,
    output logic [EV_W-1:0]               clr_mask
);
    localparam int HI_W = PC_W - DATA_W;

    typedef struct packed {
        logic [ARM_W-1:0]           arm;
        logic [DATA_W-1:0]          step;
        logic [NUM_BP-1:0][PC_W-1:0] bp;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_en;

    always_comb begin
        r_d      = r_q;
        wr_en    = psel && penable && pwrite;
        clr_mask = '0;
        if (wr_en) begin
            if (paddr == ADDR_W'(OFF_ARM))  r_d.arm  = pwdata[ARM_W-1:0];
            if (paddr == ADDR_W'(OFF_STEP)) r_d.step = pwdata;
            if (paddr == ADDR_W'(OFF_STAT)) clr_mask = pwdata[EV_W-1:0];
            for (int k = 0; k < NUM_BP; k++) begin
                if (paddr == ADDR_W'(OFF_BP0 + 8*k))
                    r_d.bp[k][DATA_W-1:0] = pwdata;
                if (paddr == ADDR_W'(OFF_BP0 + 8*k + 4))
                    r_d.bp[k][PC_W-1:DATA_W] = pwdata[HI_W-1:0];
            end
        end
    end

    always_comb begin
        prdata = '0;
        if (paddr == ADDR_W'(OFF_ARM))  prdata = DATA_W'(r_q.arm);
        if (paddr == ADDR_W'(OFF_STEP)) prdata = r_q.step;
        if (paddr == ADDR_W'(OFF_STAT)) prdata = DATA_W'(status);
        for (int k = 0; k < NUM_BP; k++) begin
            if (paddr == ADDR_W'(OFF_BP0 + 8*k))
                prdata = r_q.bp[k][DATA_W-1:0];
            if (paddr == ADDR_W'(OFF_BP0 + 8*k + 4))
                prdata = DATA_W'(r_q.bp[k][PC_W-1:DATA_W]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.arm  <= ARM_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign arm_ien  = r_q.arm[B_IEN];
    assign arm_fpe  = r_q.arm[B_FPE];
    assign arm_step = r_q.arm[B_STEP];
    assign arm_av   = r_q.arm[B_AV0 +: NUM_BP];
    assign arm_imm  = r_q.arm[B_IMM];
    assign step_num = r_q.step;
    assign bp_addr  = r_q.bp;
endmodule

// File: rtl/uwb_step.sv
module uwb_step #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rt_valid,
    input  logic [CNT_W-1:0] target,
    output logic             hit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } step_t;

    step_t            s_d, s_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        s_d     = s_q;
        hit     = 1'b0;
        cnt_inc = s_q.cnt + 1'b1;
        if (!en) begin
            s_d = '0;                       // disarm: count restarts at zero
        end else if (rt_valid && !s_q.done) begin
            s_d.cnt = cnt_inc;
            if (cnt_inc == target) begin
                s_d.done = 1'b1;
                hit      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/uwb_pc_match.sv
module uwb_pc_match #(
    parameter int PC_W = 64
) (
    input  logic            armed,
    input  logic            rt_valid,
    input  logic [PC_W-1:0] rt_pc,
    input  logic [PC_W-1:0] bp,
    output logic            hit
);
    assign hit = armed && rt_valid && (rt_pc == bp);
endmodule

// File: rtl/uop_bkpt_unit.sv
module uop_bkpt_unit
    import uwb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int PC_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              rt_valid,
    input  logic [PC_W-1:0]   rt_pc,
    output logic              pause_req,
    output logic              evt_ins,
    output logic              evt_step
);
    logic                        arm_ien, arm_fpe, arm_step, arm_imm;
    logic [NUM_BP-1:0]           arm_av;
    logic [DATA_W-1:0]           step_num;
    logic [NUM_BP-1:0][PC_W-1:0] bp_addr;
    logic [EV_W-1:0]             clr_mask;
    logic [EV_W-1:0]             status_d, status_q, ev_set;
    logic [NUM_BP-1:0]           bp_hit;
    logic                        step_hit;

    uwb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PC_W(PC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .status(status_q),
        .prdata(prdata), .arm_ien(arm_ien), .arm_fpe(arm_fpe),
        .arm_step(arm_step), .arm_av(arm_av), .arm_imm(arm_imm),
        .step_num(step_num), .bp_addr(bp_addr), .clr_mask(clr_mask)
    );

    uwb_step #(.CNT_W(DATA_W)) u_step (
        .clk(clk), .rst_n(rst_n), .en(arm_step), .rt_valid(rt_valid),
        .target(step_num), .hit(step_hit)
    );

    for (genvar k = 0; k < NUM_BP; k++) begin : g_bp
        uwb_pc_match #(.PC_W(PC_W)) u_match (
            .armed(arm_ien && arm_av[k]), .rt_valid(rt_valid),
            .rt_pc(rt_pc), .bp(bp_addr[k]), .hit(bp_hit[k])
        );
    end

    always_comb begin
        ev_set          = '0;
        ev_set[EV_INS]  = |bp_hit;
        ev_set[EV_STEP] = step_hit;
        ev_set[EV_IMM]  = arm_imm && rt_valid;
        status_d        = (status_q & ~clr_mask) | ev_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign pause_req = arm_fpe && (|status_q);
    assign evt_ins   = status_q[EV_INS];
    assign evt_step  = status_q[EV_STEP];
endmodule

// File: rtl/uwb_chk.sv
module uwb_chk
    import uwb_pkg::*;
#(
    parameter int PC_W = 64
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        rt_valid,
    input logic [PC_W-1:0]             rt_pc,
    input logic                        arm_ien,
    input logic                        arm_fpe,
    input logic [NUM_BP-1:0]           arm_av,
    input logic                        arm_imm,
    input logic [NUM_BP-1:0][PC_W-1:0] bp_addr,
    input logic [EV_W-1:0]             clr_mask,
    input logic [EV_W-1:0]             status_q,
    input logic                        pause_req
);
    // R6: exact PC match on an armed breakpoint raises the break flag
    p_bp0_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && arm_ien && arm_av[0] && rt_pc == bp_addr[0]) |=> status_q[EV_INS]);
    p_bp1_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && arm_ien && arm_av[1] && rt_pc == bp_addr[1]) |=> status_q[EV_INS]);

    // R7: retire while immediate pause is requested raises its flag
    p_imm_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && arm_imm) |=> status_q[EV_IMM]);

    // R10: no retire, no newly raised flag
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_valid |=> ((status_q & ~$past(status_q)) == '0));

    // R8: a flag stays until a write of one clears it
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[EV_STEP] && !clr_mask[EV_STEP]) |=> status_q[EV_STEP]);

    // R9: no pause without the force-pause enable or without a flag
    p_pause_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_fpe || status_q == '0) |-> !pause_req);
endmodule

bind uop_bkpt_unit uwb_chk #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rt_valid(rt_valid), .rt_pc(rt_pc),
    .arm_ien(arm_ien), .arm_fpe(arm_fpe), .arm_av(arm_av), .arm_imm(arm_imm),
    .bp_addr(bp_addr), .clr_mask(clr_mask), .status_q(status_q),
    .pause_req(pause_req)
);

// File: tb/sim_uop_bkpt_unit.sv
`timescale 1ns/1ps
module sim_uop_bkpt_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        rt_valid = 1'b0;
    logic [63:0] rt_pc = '0;
    logic        pause_req, evt_ins, evt_step;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    uop_bkpt_unit u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .rt_valid(rt_valid), .rt_pc(rt_pc), .pause_req(pause_req),
        .evt_ins(evt_ins), .evt_step(evt_step)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        #1 d = prdata;
        psel = 1'b0;
    endtask

    task automatic retire(input logic [63:0] pc);
        @(negedge clk);
        rt_valid = 1'b1; rt_pc = pc;
        @(negedge clk);
        rt_valid = 1'b0;
    endtask

    task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, {32'h0, v}, {32'h0, exp});
    endtask

    function automatic logic exp_ins(input logic [63:0] pc, input logic [8:0] arm,
                                     input logic [63:0] b0, input logic [63:0] b1);
        return arm[0] && ((arm[4] && pc == b0) || (arm[5] && pc == b1));
    endfunction

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: run hung, got=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] b0, b1, pc;
        logic [8:0]  arm;
        void'($urandom(32'h0BAD5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rchk("R1 arm reset", 12'h004, 32'h7);
        rchk("R1 step reset", 12'h008, 32'h0);
        rchk("R1 addr reset", 12'h01C, 32'h0);
        rchk("R1 status reset", 12'h040, 32'h0);
        chk("R1 pause reset", {63'h0, pause_req}, 64'h0);

        // R2 register readback
        wr(12'h008, 32'hA5A5_0003); rchk("R2 step", 12'h008, 32'hA5A5_0003);
        wr(12'h018, 32'h1111_2222); rchk("R2 a0lo", 12'h018, 32'h1111_2222);
        wr(12'h01C, 32'h3333_4444); rchk("R2 a0hi", 12'h01C, 32'h3333_4444);
        wr(12'h020, 32'h5555_6666); rchk("R2 a1lo", 12'h020, 32'h5555_6666);
        wr(12'h024, 32'h7777_8888); rchk("R2 a1hi", 12'h024, 32'h7777_8888);
        wr(12'h004, 32'hFFFF_FE00); rchk("R2 arm upper", 12'h004, 32'h0);
        wr(12'h004, 32'h0000_0007);

        // R3 unimplemented offsets
        wr(12'h00C, 32'hFFFF_FFFF); rchk("R3 0x00C", 12'h00C, 32'h0);
        wr(12'h005, 32'hFFFF_FFFF); rchk("R3 0x005", 12'h005, 32'h0);
        wr(12'h3FC, 32'hFFFF_FFFF); rchk("R3 0x3FC", 12'h3FC, 32'h0);
        rchk("R3 arm untouched", 12'h004, 32'h7);
        rchk("R3 step untouched", 12'h008, 32'hA5A5_0003);

        // R4 step count of 3
        wr(12'h008, 32'd3);
        wr(12'h004, 32'h00F);
        retire(64'h10); retire(64'h11);
        chk("R4 no flag after 2", {63'h0, evt_step}, 64'h0);
        retire(64'h12);
        chk("R4 flag at 3", {63'h0, evt_step}, 64'h1);
        chk("R9 pause with flag", {63'h0, pause_req}, 64'h1);
        retire(64'h13);
        wr(12'h040, 32'h7);
        repeat (4) retire(64'h20);
        chk("R4 fires once per arming", {63'h0, evt_step}, 64'h0);

        // R5 partial count then disarm/rearm
        wr(12'h004, 32'h007); wr(12'h004, 32'h00F);
        retire(64'h30); retire(64'h31);
        wr(12'h004, 32'h007); wr(12'h004, 32'h00F);
        retire(64'h32); retire(64'h33);
        chk("R5 count restarted", {63'h0, evt_step}, 64'h0);
        retire(64'h34);
        chk("R5 fires at 3 after rearm", {63'h0, evt_step}, 64'h1);
        wr(12'h004, 32'h007); wr(12'h040, 32'h7);

        // R4 zero step count never fires
        wr(12'h008, 32'd0); wr(12'h004, 32'h00F);
        repeat (5) retire(64'h40);
        chk("R4 zero count", {63'h0, evt_step}, 64'h0);
        wr(12'h004, 32'h007);

        // R6 address breakpoints
        b0 = 64'h0123_4567_89AB_CDEF;
        b1 = 64'hFEDC_BA98_7654_3210;
        wr(12'h018, b0[31:0]); wr(12'h01C, b0[63:32]);
        wr(12'h020, b1[31:0]); wr(12'h024, b1[63:32]);
        wr(12'h004, 32'h017);
        retire(b0 ^ (64'h1 << 40));
        chk("R6 high-word mismatch", {63'h0, evt_ins}, 64'h0);
        retire(b1);
        chk("R6 bp1 not valid", {63'h0, evt_ins}, 64'h0);

        // R10 idle cycles carrying a matching PC
        @(negedge clk); rt_pc = b0;
        repeat (3) @(negedge clk);
        chk("R10 no retire no flag", {63'h0, evt_ins}, 64'h0);

        retire(b0);
        chk("R6 bp0 match", {63'h0, evt_ins}, 64'h1);
        wr(12'h040, 32'h1);
        wr(12'h004, 32'h026);               // enable bit 0 clear, bp1 valid
        retire(b1);
        chk("R6 enable clear", {63'h0, evt_ins}, 64'h0);
        wr(12'h004, 32'h027);
        retire(b1);
        chk("R6 bp1 match", {63'h0, evt_ins}, 64'h1);

        // R9 pause gating
        wr(12'h004, 32'h023);
        chk("R9 no force-pause", {63'h0, pause_req}, 64'h0);
        wr(12'h004, 32'h027);
        chk("R9 force-pause set", {63'h0, pause_req}, 64'h1);

        // R8 sticky and partial write-one-to-clear
        wr(12'h008, 32'd1); wr(12'h004, 32'h02F);
        retire(64'h99);
        rchk("R8 two flags", 12'h040, 32'h3);
        wr(12'h040, 32'h1);
        rchk("R8 clear bit0 only", 12'h040, 32'h2);
        wr(12'h040, 32'h0);
        rchk("R8 write zero keeps", 12'h040, 32'h2);
        wr(12'h004, 32'h007); wr(12'h040, 32'h7);
        rchk("R8 cleared", 12'h040, 32'h0);

        // R7 immediate pause
        wr(12'h004, 32'h107);
        repeat (3) @(negedge clk);
        rchk("R7 no retire", 12'h040, 32'h0);
        retire(64'h55);
        rchk("R7 after retire", 12'h040, 32'h4);
        chk("R7 pause", {63'h0, pause_req}, 64'h1);
        wr(12'h004, 32'h007); wr(12'h040, 32'h7);

        // random phase: breakpoints (R6, R9)
        b0 = {$urandom, $urandom};
        b1 = {$urandom, $urandom};
        wr(12'h018, b0[31:0]); wr(12'h01C, b0[63:32]);
        wr(12'h020, b1[31:0]); wr(12'h024, b1[63:32]);
        for (int i = 0; i < 200; i++) begin
            arm = 9'h004 | 9'($urandom % 2) | (9'($urandom % 2) << 4) | (9'($urandom % 2) << 5);
            wr(12'h004, {23'h0, arm});
            case ($urandom % 4)
                0: pc = b0;
                1: pc = b1;
                2: pc = b0 ^ (64'h1 << ($urandom % 64));
                default: pc = {$urandom, $urandom};
            endcase
            retire(pc);
            chk("R6 random flag", {63'h0, evt_ins}, {63'h0, exp_ins(pc, arm, b0, b1)});
            chk("R9 random pause", {63'h0, pause_req}, {63'h0, exp_ins(pc, arm, b0, b1)});
            wr(12'h040, 32'h7);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule